// File: doc/BRIEF.md
# Sampling Converter Capture Controller

This block runs a parallel 14-bit sampling converter from the system clock. While enabled, it sends a periodic start-convert pulse whose period and high time come from configuration inputs. It holds the converter's active-low output-enable asserted. It captures each result word and its overflow bit on the falling edge of every pulse.

The converter returns results with one conversion of delay. The word read at the end of pulse k therefore belongs to the conversion that pulse k-1 started. The block credits each word to the correct sample, drops the first read after enabling, and converts the complementary offset binary code to a signed two's-complement value. Each result goes out on a valid/ready stream tagged with a running sample index.

If the consumer has not taken the previous result when the next word is captured, the new word replaces the old one and a sticky missed-sample flag is raised. At 100 MHz the reset configuration of 10 ticks per period and 5 ticks high gives 10 Msample/s with a 50 ns pulse.

Top module: `adc_capture_ctrl`

## Requirements
- R1: While `enable` is high, `adc_start_o` rises at the first cycle of every period and stays high for the effective high time in cycles. The first period begins one cycle after `enable` is first seen high. While `enable` is low the pulse stays low.
- R2: Effective period = `period_cfg`, or 2 if the setting is below 2. Effective high time = `high_cfg`, but 1 if the setting is 0 and (effective period - 1) if the setting is at or above the effective period. Both settings are loaded when the block is enabled and again at every period boundary.
- R3: The converter word and overflow bit are sampled in the first low cycle after each pulse. Counting pulses from 0 after enabling, the word sampled after pulse k (k >= 1) is reported as sample k-1. The word sampled after pulse 0 is dropped.
- R4: `adc_oe_n_o` is low in every cycle in which the pulse timer runs, and high otherwise.
- R5: A result presented with `out_valid_o` high stays valid until `out_ready_i` is high at a clock edge. Its data, overflow and index do not change meanwhile unless a newer capture replaces it.
- R6: `out_data_o` is the signed value 8191 minus the 14-bit input code, read as an unsigned integer. Thus code 0 gives +8191, code 8191 gives 0 and code 16383 gives -8192. `out_ovf_o` carries the overflow bit sampled with that code.
- R7: `out_index_o` is 0 for the first reported sample after each enable and increases by one per reported sample.
- R8: `missed_o` goes high when a capture lands while `out_valid_o` is high and `out_ready_i` is low. It stays high until `enable` is low at a clock edge or reset.
- R9: In reset, and one cycle after `enable` is seen low, `adc_start_o` is low, `adc_oe_n_o` is high, `out_valid_o` is low, `missed_o` is low and the sample index restarts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Runs the pulse timer and capture |
| period_cfg | input | PER_W | Requested sample period in clock cycles |
| high_cfg | input | PER_W | Requested start pulse high time in clock cycles |
| adc_data_i | input | 14 | Converter result word, complementary offset binary |
| adc_ovf_i | input | 1 | Converter overflow bit |
| adc_start_o | output | 1 | Start-convert pulse, rising edge starts a conversion |
| adc_oe_n_o | output | 1 | Active-low converter output enable |
| out_valid_o | output | 1 | Result available |
| out_ready_i | input | 1 | Consumer accepts the result |
| out_data_o | output | 14 | Signed two's-complement sample |
| out_ovf_o | output | 1 | Overflow bit of the sample |
| out_index_o | output | IDX_W | Sample index since enable |
| missed_o | output | 1 | Sticky: a result was overwritten before being taken |

## Verification
The properties assume that `enable`, the configuration inputs and `out_ready_i` change only between clock edges. They also assume that a converter word is stable in the cycle after each pulse falls. The bench drives every input a short delay after the rising edge. Its converter model changes the word right after each pulse rises, so the word is always settled at least one full cycle before it is sampled. Backpressure phases hold `out_ready_i` low across several periods to force overwrites. Configuration phases use settings below the minimum and above the period so that both clamp rules are exercised.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  localparam int unsigned CODE_W = 14;

  typedef struct packed {
    logic              ovf;
    logic [CODE_W-1:0] code;
  } raw_word_t;

  typedef struct packed {
    logic                     ovf;
    logic signed [CODE_W-1:0] value;
  } result_t;
endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int unsigned PER_W   = 8,
  parameter int unsigned DEF_PER = 10,
  parameter int unsigned DEF_HI  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PER_W-1:0] per_cfg,
  input  logic [PER_W-1:0] hi_cfg,
  output logic             start_o,
  output logic             cap_o,
  output logic             active_o
);
  localparam logic [PER_W-1:0] MIN_PER = PER_W'(2);
  localparam logic [PER_W-1:0] ONE     = PER_W'(1);

  logic             active_q, active_d;
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] per_q, per_d;
  logic [PER_W-1:0] hi_q, hi_d;
  logic [PER_W-1:0] per_eff, hi_eff;

  // clamp the requested timing
  always_comb begin
    per_eff = (per_cfg < MIN_PER) ? MIN_PER : per_cfg;
    if (hi_cfg == '0)          hi_eff = ONE;
    else if (hi_cfg >= per_eff) hi_eff = per_eff - ONE;
    else                        hi_eff = hi_cfg;
  end

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    per_d    = per_q;
    hi_d     = hi_q;
    if (!run) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else if (!active_q) begin
      active_d = 1'b1;
      cnt_d    = '0;
      per_d    = per_eff;
      hi_d     = hi_eff;
    end else if (cnt_q == per_q - ONE) begin
      cnt_d = '0;
      per_d = per_eff;
      hi_d  = hi_eff;
    end else begin
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      per_q    <= PER_W'(DEF_PER);
      hi_q     <= PER_W'(DEF_HI);
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      per_q    <= per_d;
      hi_q     <= hi_d;
    end
  end

  assign start_o  = active_q && (cnt_q < hi_q);
  assign cap_o    = active_q && (cnt_q == hi_q);
  assign active_o = active_q;
endmodule

// File: rtl/adc_code_fmt.sv
module adc_code_fmt
  import adc_cap_pkg::*;
(
  input  raw_word_t raw_i,
  output result_t   res_o
);
  // complementary offset binary: keep the top bit, flip the rest
  always_comb begin
    res_o.ovf   = raw_i.ovf;
    res_o.value = {raw_i.code[CODE_W-1], ~raw_i.code[CODE_W-2:0]};
  end
endmodule

// File: rtl/adc_result_stage.sv
module adc_result_stage
  import adc_cap_pkg::*;
#(
  parameter int unsigned IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cap,
  input  result_t          res_i,
  input  logic             ready_i,
  output logic             valid_o,
  output result_t          res_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             missed_o
);
  logic             primed_q, primed_d;
  logic [IDX_W-1:0] seq_q, seq_d;
  logic             valid_q, valid_d;
  result_t          res_q, res_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             missed_q, missed_d;

  always_comb begin
    primed_d = primed_q;
    seq_d    = seq_q;
    valid_d  = valid_q;
    res_d    = res_q;
    idx_d    = idx_q;
    missed_d = missed_q;
    if (!run) begin
      primed_d = 1'b0;
      seq_d    = '0;
      valid_d  = 1'b0;
      missed_d = 1'b0;
    end else begin
      if (valid_q && ready_i) valid_d = 1'b0;
      if (cap) begin
        if (!primed_q) begin
          primed_d = 1'b1;
        end else begin
          if (valid_q && !ready_i) missed_d = 1'b1;
          valid_d = 1'b1;
          res_d   = res_i;
          idx_d   = seq_q;
          seq_d   = seq_q + IDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      seq_q    <= '0;
      valid_q  <= 1'b0;
      res_q    <= '0;
      idx_q    <= '0;
      missed_q <= 1'b0;
    end else begin
      primed_q <= primed_d;
      seq_q    <= seq_d;
      valid_q  <= valid_d;
      res_q    <= res_d;
      idx_q    <= idx_d;
      missed_q <= missed_d;
    end
  end

  assign valid_o  = valid_q;
  assign res_o    = res_q;
  assign idx_o    = idx_q;
  assign missed_o = missed_q;
endmodule

// File: rtl/adc_capture_ctrl.sv
module adc_capture_ctrl
  import adc_cap_pkg::*;
#(
  parameter int unsigned PER_W   = 8,
  parameter int unsigned IDX_W   = 16,
  parameter int unsigned DEF_PER = 10,
  parameter int unsigned DEF_HI  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic [PER_W-1:0]         period_cfg,
  input  logic [PER_W-1:0]         high_cfg,
  input  logic [CODE_W-1:0]        adc_data_i,
  input  logic                     adc_ovf_i,
  output logic                     adc_start_o,
  output logic                     adc_oe_n_o,
  output logic                     out_valid_o,
  input  logic                     out_ready_i,
  output logic signed [CODE_W-1:0] out_data_o,
  output logic                     out_ovf_o,
  output logic [IDX_W-1:0]         out_index_o,
  output logic                     missed_o
);
  logic      rst_int_n;
  logic      run;
  logic      cap;
  logic      active;
  raw_word_t raw;
  result_t   fmt_res, out_res;

  adc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign run = enable;

  adc_conv_timer #(
    .PER_W   (PER_W),
    .DEF_PER (DEF_PER),
    .DEF_HI  (DEF_HI)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (run),
    .per_cfg  (period_cfg),
    .hi_cfg   (high_cfg),
    .start_o  (adc_start_o),
    .cap_o    (cap),
    .active_o (active)
  );

  assign raw.code = adc_data_i;
  assign raw.ovf  = adc_ovf_i;

  adc_code_fmt u_fmt (
    .raw_i (raw),
    .res_o (fmt_res)
  );

  adc_result_stage #(.IDX_W(IDX_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (run),
    .cap      (cap),
    .res_i    (fmt_res),
    .ready_i  (out_ready_i),
    .valid_o  (out_valid_o),
    .res_o    (out_res),
    .idx_o    (out_index_o),
    .missed_o (missed_o)
  );

  assign adc_oe_n_o = !active;
  assign out_data_o = out_res.value;
  assign out_ovf_o  = out_res.ovf;
endmodule

// File: rtl/adc_capture_ctrl_chk.sv
module adc_capture_ctrl_chk #(
  parameter int unsigned IDX_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             adc_start_o,
  input logic             adc_oe_n_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [13:0]      out_data_o,
  input logic [IDX_W-1:0] out_index_o,
  input logic             missed_o
);
  assert_start_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !adc_start_o);

  assert_oe_with_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start_o |-> !adc_oe_n_o);

  assert_valid_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i && enable) |=> out_valid_o);

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i && enable) |=> ($stable(out_data_o) || missed_o));

  assert_index_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i && enable) |=> ($stable(out_index_o) || missed_o));

  assert_missed_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (missed_o && enable) |=> missed_o);

  assert_idle_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!out_valid_o && !missed_o));
endmodule

bind adc_capture_ctrl adc_capture_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .adc_start_o (adc_start_o),
  .adc_oe_n_o  (adc_oe_n_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_index_o (out_index_o),
  .missed_o    (missed_o)
);

// File: tb/tb_adc_capture_ctrl.sv
`timescale 1ns/1ps
module tb_adc_capture_ctrl;
  localparam int PER_W = 8;
  localparam int IDX_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [PER_W-1:0] period_cfg = 8'd10;
  logic [PER_W-1:0] high_cfg = 8'd5;
  logic [13:0] adc_data_i = 14'h1555;
  logic adc_ovf_i = 1'b0;
  logic out_ready_i = 1'b1;
  logic adc_start_o, adc_oe_n_o, out_valid_o, out_ovf_o, missed_o;
  logic signed [13:0] out_data_o;
  logic [IDX_W-1:0] out_index_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  adc_capture_ctrl #(.PER_W(PER_W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .period_cfg(period_cfg), .high_cfg(high_cfg),
    .adc_data_i(adc_data_i), .adc_ovf_i(adc_ovf_i),
    .adc_start_o(adc_start_o), .adc_oe_n_o(adc_oe_n_o),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_data_o(out_data_o), .out_ovf_o(out_ovf_o),
    .out_index_o(out_index_o), .missed_o(missed_o)
  );

  function automatic int code_of(int k);
    case (k)
      0: return 0;
      1: return 8191;
      2: return 16383;
      3: return 8192;
      4: return 1;
      5: return 16382;
      default: return (k * 2731 + 77) % 16384;
    endcase
  endfunction

  function automatic bit ovf_of(int k);
    return (k % 7) == 4;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // converter model: new word appears just after each pulse rises
  int rises = 0;
  logic prev_start = 1'b0;
  always @(posedge clk) begin
    #1;
    if (!enable && !adc_start_o) rises = 0;
    else if (adc_start_o && !prev_start) begin
      if (rises >= 1) begin
        adc_data_i = 14'(code_of(rises - 1));
        adc_ovf_i  = ovf_of(rises - 1);
      end else begin
        adc_data_i = 14'h2AAA;
        adc_ovf_i  = 1'b1;
      end
      rises++;
    end
    prev_start = adc_start_o;
  end

  // behavioural reference, compared every cycle
  bit m_active = 0;
  int m_t = 0, m_per = 10, m_hi = 5, m_pulses = 0;
  bit m_valid = 0, m_ovf = 0, m_missed = 0;
  int m_val = 0, m_idx = 0;
  string tag_start = "R1";

  always @(negedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_t = 0; m_pulses = 0; m_valid = 0; m_missed = 0;
    end else if (!done) begin
      bit cap;
      int pe;
      check(tag_start, adc_start_o, (m_active && m_t < m_hi) ? 1 : 0);
      check("R4", adc_oe_n_o, m_active ? 0 : 1);
      check("R5", out_valid_o, m_valid);
      check("R8", missed_o, m_missed);
      if (m_valid) begin
        check("R3 R6 data", out_data_o, m_val);
        check("R6 ovf", out_ovf_o, m_ovf);
        check("R7", out_index_o, m_idx);
      end
      cap = m_active && (m_t == m_hi);
      pe = (period_cfg < 2) ? 2 : period_cfg;
      if (!enable) begin
        m_active = 0; m_t = 0; m_pulses = 0; m_valid = 0; m_missed = 0;
      end else if (!m_active) begin
        m_active = 1; m_t = 0; m_pulses = 0;
        m_per = pe;
        m_hi = (high_cfg == 0) ? 1 : ((high_cfg >= pe) ? pe - 1 : high_cfg);
      end else begin
        if (m_valid && out_ready_i) m_valid = 0;
        if (cap) begin
          if (m_pulses > 0) begin
            if (out_valid_o && !out_ready_i) m_missed = 1;
            m_valid = 1;
            m_val = 8191 - code_of(m_pulses - 1);
            m_ovf = ovf_of(m_pulses - 1);
            m_idx = m_pulses - 1;
          end
          m_pulses++;
        end
        if (m_t == m_per - 1) begin
          m_t = 0; m_per = pe;
          m_hi = (high_cfg == 0) ? 1 : ((high_cfg >= pe) ? pe - 1 : high_cfg);
        end else m_t++;
      end
    end
  end

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    #35;
    // R9: reset state
    check("R9 start", adc_start_o, 0);
    check("R9 oe", adc_oe_n_o, 1);
    check("R9 valid", out_valid_o, 0);
    check("R9 missed", missed_o, 0);
    rst_n = 1'b1;
    cycles(6);
    // default timing, consumer always ready
    enable = 1'b1;
    cycles(150);
    // backpressure: overwrites set missed (R8)
    out_ready_i = 1'b0;
    cycles(45);
    out_ready_i = 1'b1;
    cycles(30);
    // toggling ready
    for (int i = 0; i < 60; i++) begin
      out_ready_i = (i % 3) != 0;
      cycles(1);
    end
    out_ready_i = 1'b1;
    // R2: high above period clamps
    tag_start = "R2";
    period_cfg = 8'd7; high_cfg = 8'd9;
    cycles(60);
    // R2: period below minimum, high zero
    period_cfg = 8'd1; high_cfg = 8'd0;
    cycles(40);
    // R9: disable clears state
    enable = 1'b0;
    cycles(1);
    check("R9 start off", adc_start_o, 0);
    check("R9 oe off", adc_oe_n_o, 1);
    check("R9 valid off", out_valid_o, 0);
    check("R9 missed off", missed_o, 0);
    cycles(5);
    // re-enable with new timing: index restarts (R7), first word dropped (R3)
    tag_start = "R1";
    period_cfg = 8'd16; high_cfg = 8'd3;
    enable = 1'b1;
    cycles(200);
    out_ready_i = 1'b0;
    cycles(50);
    out_ready_i = 1'b1;
    cycles(40);
    period_cfg = 8'd10; high_cfg = 8'd10;
    cycles(60);
    finish_run();
  end
endmodule